// File: doc/BRIEF.md
# EEPROM Access and Burst Loader

This block gives a host two ways to reach a byte-wide EEPROM. Through a small register set the host can move a single byte: it places an EEPROM address and, for a store, a data byte, then raises a request bit in the control register. The hardware performs the access and drops the bit when it is finished. Once a read request bit reads 0 again, the data register holds the fetched byte.

The second path is a burst loader. A single start bit makes the block walk a chain of records stored in the EEPROM. Each record carries a count byte, a two-byte destination (low byte first) and that many data bytes. A count of zero ends the chain. Each data byte turns into one write on an internal memory port. The destination address is 24 bits wide. Its upper 9 bits come from a base register and its lower 15 bits come from the record; the top bit of the record's 16-bit address is discarded.

The burst start address depends on what happened before. If no EEPROM access has completed since reset, the burst begins at EEPROM address 0. Otherwise it begins one past the most recently accessed address. The EEPROM side uses a request held until a one-cycle ready pulse, with one access outstanding at a time.

Top module: `eeprom_burst_loader`

## Requirements
- R1: After reset, every register reads 0, `ee_req` and `mem_we` are low, and no access is in progress.
- R2: Register selects are: 0 = EEPROM address (16 bits); 1 = data (8 bits, upper bits read 0); 2 = control; 3 = burst start; 4 = base (9 bits). Writes to selects 0, 1 and 4 are read back with only their implemented bits, and an unused select reads 0.
- R3: Writing control with bit 1 set (and bit 0 clear) performs one EEPROM read (`ee_we`=0) at the address register. When the access completes, the byte is placed in the data register.
- R4: Writing control with bit 0 set performs one EEPROM write (`ee_we`=1) of the data register's byte at the address register. If bits 0 and 1 are both set, only the write is performed.
- R5: `ee_req` stays high with `ee_addr`, `ee_we` and `ee_wdata` stable until a cycle in which `ee_rdy` is high. It is low in the following cycle.
- R6: A burst begins at EEPROM address 0 if no access has completed since reset. Otherwise it begins at the address one past the last completed access, and this applies to single and burst accesses alike.
- R7: A burst reads records made of a count byte, a destination low byte, a destination high byte and then count data bytes. It stops after reading a zero count byte, and burst bit 0 then reads 0. A burst never issues an EEPROM write.
- R8: Each burst data byte produces exactly one `mem_we` pulse, in the cycle right after its EEPROM ready cycle. The address is {base[8:0], destination[14:0]}, where destination bit 15 is ignored and the low 15 bits increase by one per byte and wrap modulo 2^15.
- R9: While an access or burst is in progress, control bit 2 (busy) reads 1. Writes to the control and burst-start registers are ignored during that time.
- R10: Control bit 1 reads 1 while a single read is pending, control bit 0 reads 1 while a single write is pending, and burst bit 0 reads 1 while a burst runs. Each of these bits is visible from the cycle after the register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for `host_sel` (combinational) |
| ee_req | output | 1 | EEPROM access request |
| ee_we | output | 1 | EEPROM access is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_rdy | input | 1 | EEPROM access done (one-cycle pulse) |
| ee_rdata | input | 8 | EEPROM read byte, valid with `ee_rdy` |
| mem_we | output | 1 | Internal memory byte write strobe |
| mem_addr | output | 24 | Internal memory address |
| mem_wdata | output | 8 | Internal memory write byte |

## Verification
A register write takes effect at the next rising edge. From the following cycle, control and burst readback show the pending state and `ee_req` rises one cycle later. A single access completes on the clock edge that samples `ee_rdy`, so the data register and the cleared control bit are visible in the cycle after the ready pulse. A memory write appears exactly one cycle after the ready cycle of its data byte. The scoreboard compares each EEPROM access and memory write on the falling edge of the cycle in which it completes, and flags a memory write that does not directly follow a ready cycle. Register results are read only after the busy bit has been polled back to 0, always on falling edges.

// File: rtl/eebl_pkg.sv
package eebl_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_ADDR  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DATA  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_BURST = 3'd3;
  localparam logic [SEL_W-1:0] SEL_BASE  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SINGLE,
    ST_CNT,
    ST_ALO,
    ST_AHI,
    ST_DATA
  } eebl_state_e;
endpackage

// File: rtl/eebl_regs.sv
module eebl_regs
  import eebl_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [SEL_W-1:0]    host_sel,
  input  logic [EE_AW-1:0]    host_wdata,
  input  logic                idle,
  input  logic                rd_pend,
  input  logic                wr_pend,
  input  logic                burst_pend,
  input  logic                load_en,
  input  logic [BYTE_W-1:0]   load_byte,
  output logic [EE_AW-1:0]    addr_q,
  output logic [BYTE_W-1:0]   data_q,
  output logic [BASE_W-1:0]   base_q,
  output logic [EE_AW-1:0]    host_rdata,
  output logic                go_read,
  output logic                go_write,
  output logic                go_burst
);
  logic              addr_en, data_en, base_en;
  logic [BYTE_W-1:0] data_d;

  // write decode; requests only accepted when the engine is idle
  always_comb begin
    addr_en  = host_wr && (host_sel == SEL_ADDR);
    base_en  = host_wr && (host_sel == SEL_BASE);
    data_en  = load_en || (host_wr && (host_sel == SEL_DATA));
    data_d   = load_en ? load_byte : host_wdata[BYTE_W-1:0];
    go_write = host_wr && idle && (host_sel == SEL_CTRL) && host_wdata[0];
    go_read  = host_wr && idle && (host_sel == SEL_CTRL) && host_wdata[1] && !host_wdata[0];
    go_burst = host_wr && idle && (host_sel == SEL_BURST) && host_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      base_q <= '0;
    end else begin
      if (addr_en) addr_q <= host_wdata;
      if (data_en) data_q <= data_d;
      if (base_en) base_q <= host_wdata[BASE_W-1:0];
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_ADDR:  host_rdata = addr_q;
      SEL_DATA:  host_rdata = EE_AW'(data_q);
      SEL_CTRL:  host_rdata = EE_AW'({!idle, rd_pend, wr_pend});
      SEL_BURST: host_rdata = EE_AW'(burst_pend);
      SEL_BASE:  host_rdata = EE_AW'(base_q);
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eebl_cursor.sv
module eebl_cursor #(
  parameter int EE_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [EE_AW-1:0] done_addr,
  output logic [EE_AW-1:0] next_addr
);
  // Address that a burst resumes from: 0 out of reset, else last access + 1
  logic [EE_AW-1:0] next_d;

  always_comb next_d = done_addr + EE_AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    next_addr <= '0;
    else if (step) next_addr <= next_d;
  end
endmodule

// File: rtl/eebl_engine.sv
module eebl_engine
  import eebl_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int BASE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_read,
  input  logic                go_write,
  input  logic                go_burst,
  input  logic [EE_AW-1:0]    addr_q,
  input  logic [BYTE_W-1:0]   data_q,
  input  logic [BASE_W-1:0]   base_q,
  input  logic [EE_AW-1:0]    next_addr,
  input  logic                ee_rdy,
  input  logic [BYTE_W-1:0]   ee_rdata,
  output logic                ee_req,
  output logic                ee_we,
  output logic [EE_AW-1:0]    ee_addr,
  output logic [BYTE_W-1:0]   ee_wdata,
  output logic                mem_we,
  output logic [MEM_AW-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                step,
  output logic                load_en,
  output logic                idle,
  output logic                rd_pend,
  output logic                wr_pend,
  output logic                burst_pend
);
  localparam int LOW_W = MEM_AW - BASE_W;

  eebl_state_e        state_q, state_d;
  logic               req_q, req_d;
  logic               we_q, we_d;
  logic [EE_AW-1:0]   ptr_q, ptr_d;
  logic [BYTE_W-1:0]  wb_q, wb_d;
  logic [BYTE_W-1:0]  cnt_q, cnt_d;
  logic [LOW_W-1:0]   dst_q, dst_d;
  logic               mem_we_d;
  logic [MEM_AW-1:0]  mem_addr_d;
  logic [BYTE_W-1:0]  mem_wdata_d;
  logic               done;

  always_comb begin
    done       = req_q && ee_rdy;
    idle       = (state_q == ST_IDLE);
    rd_pend    = (state_q == ST_SINGLE) && !we_q;
    wr_pend    = (state_q == ST_SINGLE) && we_q;
    burst_pend = !idle && (state_q != ST_SINGLE);
    step       = done;
    load_en    = done && rd_pend;
    ee_req     = req_q;
    ee_we      = we_q;
    ee_addr    = ptr_q;
    ee_wdata   = wb_q;
  end

  always_comb begin
    state_d     = state_q;
    req_d       = req_q;
    we_d        = we_q;
    ptr_d       = ptr_q;
    wb_d        = wb_q;
    cnt_d       = cnt_q;
    dst_d       = dst_q;
    mem_we_d    = 1'b0;
    mem_addr_d  = mem_addr;
    mem_wdata_d = mem_wdata;
    if (state_q == ST_IDLE) begin
      if (go_write || go_read) begin
        state_d = ST_SINGLE;
        ptr_d   = addr_q;
        we_d    = go_write;
        wb_d    = data_q;
      end else if (go_burst) begin
        state_d = ST_CNT;
        ptr_d   = next_addr;
        we_d    = 1'b0;
      end
    end else if (!req_q) begin
      req_d = 1'b1;
    end else if (ee_rdy) begin
      req_d = 1'b0;
      if (state_q != ST_SINGLE) ptr_d = ptr_q + EE_AW'(1);
      unique case (state_q)
        ST_SINGLE: state_d = ST_IDLE;
        ST_CNT: begin
          if (ee_rdata == '0) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d   = ee_rdata;
            state_d = ST_ALO;
          end
        end
        ST_ALO: begin
          dst_d   = LOW_W'(ee_rdata);
          state_d = ST_AHI;
        end
        ST_AHI: begin
          // truncation drops the record's top address bit
          dst_d   = LOW_W'({ee_rdata, dst_q[BYTE_W-1:0]});
          state_d = ST_DATA;
        end
        ST_DATA: begin
          mem_we_d    = 1'b1;
          mem_addr_d  = {base_q, dst_q};
          mem_wdata_d = ee_rdata;
          dst_d       = dst_q + LOW_W'(1);
          cnt_d       = cnt_q - BYTE_W'(1);
          if (cnt_q == BYTE_W'(1)) state_d = ST_CNT;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      ptr_q     <= '0;
      wb_q      <= '0;
      cnt_q     <= '0;
      dst_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state_q   <= state_d;
      req_q     <= req_d;
      we_q      <= we_d;
      ptr_q     <= ptr_d;
      wb_q      <= wb_d;
      cnt_q     <= cnt_d;
      dst_q     <= dst_d;
      mem_we    <= mem_we_d;
      mem_addr  <= mem_addr_d;
      mem_wdata <= mem_wdata_d;
    end
  end
endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
  import eebl_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int BASE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [SEL_W-1:0]    host_sel,
  input  logic [EE_AW-1:0]    host_wdata,
  output logic [EE_AW-1:0]    host_rdata,
  output logic                ee_req,
  output logic                ee_we,
  output logic [EE_AW-1:0]    ee_addr,
  output logic [BYTE_W-1:0]   ee_wdata,
  input  logic                ee_rdy,
  input  logic [BYTE_W-1:0]   ee_rdata,
  output logic                mem_we,
  output logic [MEM_AW-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata
);
  logic [EE_AW-1:0]  addr_q, next_addr;
  logic [BYTE_W-1:0] data_q;
  logic [BASE_W-1:0] base_q;
  logic go_read, go_write, go_burst;
  logic step, load_en, idle, busy, rd_pend, wr_pend, burst_pend;

  assign busy = !idle;

  eebl_regs #(.EE_AW(EE_AW), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .idle(idle), .rd_pend(rd_pend), .wr_pend(wr_pend), .burst_pend(burst_pend),
    .load_en(load_en), .load_byte(ee_rdata),
    .addr_q(addr_q), .data_q(data_q), .base_q(base_q),
    .host_rdata(host_rdata),
    .go_read(go_read), .go_write(go_write), .go_burst(go_burst)
  );

  eebl_cursor #(.EE_AW(EE_AW)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .step(step), .done_addr(ee_addr), .next_addr(next_addr)
  );

  eebl_engine #(.EE_AW(EE_AW), .MEM_AW(MEM_AW), .BASE_W(BASE_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .go_read(go_read), .go_write(go_write), .go_burst(go_burst),
    .addr_q(addr_q), .data_q(data_q), .base_q(base_q), .next_addr(next_addr),
    .ee_rdy(ee_rdy), .ee_rdata(ee_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .step(step), .load_en(load_en), .idle(idle),
    .rd_pend(rd_pend), .wr_pend(wr_pend), .burst_pend(burst_pend)
  );
endmodule

// File: rtl/eebl_checker.sv
module eebl_checker #(
  parameter int EE_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ee_req,
  input logic             ee_rdy,
  input logic             ee_we,
  input logic [EE_AW-1:0] ee_addr,
  input logic [7:0]       ee_wdata,
  input logic             mem_we,
  input logic             busy,
  input logic             burst_pend
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_rdy |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));

  assert_req_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_rdy |=> !ee_req);

  assert_burst_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && burst_pend |-> !ee_we);

  assert_mem_after_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(ee_req && ee_rdy));

  assert_mem_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> busy);
endmodule

bind eeprom_burst_loader eebl_checker #(.EE_AW(EE_AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_rdy(ee_rdy), .ee_we(ee_we),
  .ee_addr(ee_addr), .ee_wdata(ee_wdata), .mem_we(mem_we), .busy(busy),
  .burst_pend(burst_pend)
);

// File: tb/test_eeprom_burst_loader.sv
`timescale 1ns/1ps
module test_eeprom_burst_loader;
  localparam int LAT = 2;
  localparam logic [2:0] S_ADDR = 3'd0, S_DATA = 3'd1, S_CTRL = 3'd2, S_BURST = 3'd3, S_BASE = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [2:0]  host_sel;
  logic [15:0] host_wdata, host_rdata;
  logic        ee_req, ee_we, ee_rdy;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata, ee_rdata;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0, n_fail = 0;
  int bptr = 0;
  int wcnt = 0;
  bit finished = 0;
  bit prev_done = 0;
  logic [7:0]  ee_img [0:65535];
  logic [24:0] exp_ee[$];
  logic [31:0] exp_mem[$];
  logic [24:0] e_item;
  logic [31:0] m_item;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  eeprom_burst_loader i_eeprom_burst_loader (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_rdy(ee_rdy), .ee_rdata(ee_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural EEPROM: ready LAT+1 cycles after request seen
  initial begin
    ee_rdy = 1'b0;
    ee_rdata = '0;
    for (int i = 0; i < 65536; i++) ee_img[i] = 8'(i * 37 + 11);
    forever begin
      @(posedge clk);
      #1;
      if (ee_rdy) begin
        ee_rdy = 1'b0;
      end else if (ee_req) begin
        if (wcnt == LAT) begin
          ee_rdy = 1'b1;
          ee_rdata = ee_img[ee_addr];
          if (ee_we) ee_img[ee_addr] = ee_wdata;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        chk(prev_done, "R8 mem write not one cycle after ready", 32'(mem_we), 32'(prev_done));
        if (exp_mem.size() == 0) begin
          chk(1'b0, "R8 unexpected mem write", {mem_addr, mem_wdata}, 32'h0);
        end else begin
          m_item = exp_mem.pop_front();
          chk({mem_addr, mem_wdata} == m_item, "R8 mem write", {mem_addr, mem_wdata}, m_item);
        end
      end
      if (ee_req && ee_rdy) begin
        if (exp_ee.size() == 0) begin
          chk(1'b0, "R9 unexpected EEPROM access", {7'd0, ee_we, ee_addr, ee_wdata}, 32'h0);
        end else begin
          e_item = exp_ee.pop_front();
          chk(ee_we == e_item[24] && ee_addr == e_item[23:8] && (!e_item[24] || ee_wdata == e_item[7:0]),
              "R6/R3/R4 EEPROM access", {7'd0, ee_we, ee_addr, ee_wdata}, {7'd0, e_item});
        end
      end
      prev_done = ee_req && ee_rdy;
    end
  end

  task automatic reg_wr(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] s, output logic [15:0] v);
    host_sel = s;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    logic [15:0] v;
    do begin
      @(negedge clk);
      reg_rd(S_CTRL, v);
      n++;
    end while (v[2] && n < 5000);
    chk(!v[2], "R9 busy never cleared", 32'(v), 32'h0);
  endtask

  task automatic push_rd(input int a);
    exp_ee.push_back({1'b0, 16'(a), 8'h00});
  endtask

  task automatic add_rec(input int cnt, input logic [15:0] dst, input logic [8:0] base, input logic [7:0] seed);
    ee_img[bptr] = 8'(cnt);   push_rd(bptr); bptr++;
    ee_img[bptr] = dst[7:0];  push_rd(bptr); bptr++;
    ee_img[bptr] = dst[15:8]; push_rd(bptr); bptr++;
    for (int i = 0; i < cnt; i++) begin
      logic [14:0] d;
      d = dst[14:0] + 15'(i);
      ee_img[bptr] = seed + 8'(i);
      push_rd(bptr);
      exp_mem.push_back({base, d, seed + 8'(i)});
      bptr++;
    end
  endtask

  task automatic add_end();
    ee_img[bptr] = 8'h00; push_rd(bptr); bptr++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_sel = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      reg_rd(3'(s), rv);
      chk(rv == 16'h0, "R1 reset register value", 32'(rv), 32'h0);
    end
    chk(!ee_req && !mem_we, "R1 reset outputs", {30'd0, ee_req, mem_we}, 32'h0);

    // R2 register readback
    reg_wr(S_ADDR, 16'hBEEF); reg_rd(S_ADDR, rv);
    chk(rv == 16'hBEEF, "R2 address readback", 32'(rv), 32'hBEEF);
    reg_wr(S_DATA, 16'h01FF); reg_rd(S_DATA, rv);
    chk(rv == 16'h00FF, "R2 data keeps 8 bits", 32'(rv), 32'hFF);
    reg_wr(S_BASE, 16'hFFFF); reg_rd(S_BASE, rv);
    chk(rv == 16'h01FF, "R2 base keeps 9 bits", 32'(rv), 32'h1FF);
    reg_rd(3'd7, rv);
    chk(rv == 16'h0, "R2 unused select", 32'(rv), 32'h0);

    // R6/R7/R8 first burst starts at 0; bit 15 dropped; 15-bit wrap
    reg_wr(S_BASE, 16'h00A5);
    bptr = 0;
    add_rec(3, 16'h8005, 9'h0A5, 8'h40);
    add_rec(2, 16'h7FFF, 9'h0A5, 8'h80);
    add_end();
    reg_wr(S_BURST, 16'h0001);
    reg_rd(S_BURST, rv);
    chk(rv == 16'h1, "R10 burst bit while running", 32'(rv), 32'h1);
    reg_rd(S_CTRL, rv);
    chk(rv == 16'h4, "R9 busy during burst", 32'(rv), 32'h4);
    reg_wr(S_CTRL, 16'h0002);          // R9 ignored request
    reg_wr(S_BURST, 16'h0001);         // R9 ignored restart
    wait_idle();
    reg_rd(S_BURST, rv);
    chk(rv == 16'h0, "R7 burst bit self-clears", 32'(rv), 32'h0);
    reg_rd(S_DATA, rv);
    chk(rv == 16'h00FF, "R9 ignored read left data", 32'(rv), 32'hFF);

    // R3 single read
    reg_wr(S_ADDR, 16'h0100);
    push_rd(16'h0100);
    reg_wr(S_CTRL, 16'h0002);
    reg_rd(S_CTRL, rv);
    chk(rv == 16'h6, "R10 read bit pending", 32'(rv), 32'h6);
    wait_idle();
    reg_rd(S_DATA, rv);
    chk(rv == 16'(ee_img[16'h0100]), "R3 read data", 32'(rv), 32'(ee_img[16'h0100]));

    // R4 write wins when both bits set
    reg_wr(S_ADDR, 16'h0200);
    reg_wr(S_DATA, 16'h005A);
    exp_ee.push_back({1'b1, 16'h0200, 8'h5A});
    reg_wr(S_CTRL, 16'h0003);
    reg_rd(S_CTRL, rv);
    chk(rv == 16'h5, "R10 write bit pending", 32'(rv), 32'h5);
    wait_idle();
    reg_rd(S_CTRL, rv);
    chk(rv == 16'h0, "R4 write bit clears", 32'(rv), 32'h0);

    // R6 burst resumes after last single access
    reg_wr(S_BASE, 16'h0133);
    bptr = 16'h0201;
    add_rec(1, 16'h0010, 9'h133, 8'hC7);
    add_end();
    reg_wr(S_BURST, 16'h0001);
    wait_idle();

    // R6 back-to-back burst resumes after terminating byte
    add_end();
    reg_wr(S_BURST, 16'h0001);
    wait_idle();

    // R4 stored byte read back
    reg_wr(S_ADDR, 16'h0200);
    push_rd(16'h0200);
    reg_wr(S_CTRL, 16'h0002);
    wait_idle();
    reg_rd(S_DATA, rv);
    chk(rv == 16'h005A, "R4 written byte read back", 32'(rv), 32'h5A);

    repeat (4) @(negedge clk);
    chk(exp_ee.size() == 0, "R7 EEPROM accesses outstanding", 32'(exp_ee.size()), 32'h0);
    chk(exp_mem.size() == 0, "R8 mem writes outstanding", 32'(exp_mem.size()), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule